// File: doc/BRIEF.md
# Byte ALU with Status Flags

This block is the purely combinational arithmetic and logic unit of an 8-bit accumulator machine. Each cycle the parent presents an operation code, the accumulator, a second byte and the current carry and half-carry flags. The block returns the new byte together with new carry (C), half-carry (AC) and signed-overflow (OV) values. It also returns a separate write enable for the result and for each flag, so the parent writes back only what the operation actually changes.

Operand fetch, addressing and the flag register itself belong to the parent. A compare operation produces only a carry and a not-equal indication and leaves the accumulator alone. Decimal adjust corrects a packed-BCD sum after an addition. Its carry can become set but never clears.

Top module: `byte_alu`

## Requirements
- R1: Code 0 (add) gives A+S and code 1 (add with carry) gives A+S+C. In both, C is the carry out of bit 7, AC is the carry out of bit 3 and OV flags a signed result outside -128..127. All three flag enables and the result enable are high.
- R2: Code 2 (subtract with borrow) gives A-S-C modulo 256. C is set when A < S+C unsigned. AC is set when the low nibble of A is below the low nibble of S plus C. OV flags a signed difference outside -128..127. All enables are high.
- R3: Code 15 (compare) sets C exactly when A < S unsigned and drives the not-equal output high exactly when A differs from S. Only the C enable is high, the result enable is low and the result equals A. On every other code the not-equal output is low.
- R4: Code 16 (decimal adjust) adds 06h when the low nibble exceeds 9 or AC is set. It then adds 60h when C is set by then or the high nibble exceeds 9. C out is the incoming C ORed with any carry from either step. Only the C enable is high.
- R5: Code 12 rotates left through carry: bit 7 goes to C and the old C goes to bit 0. Code 13 rotates right through carry: bit 0 goes to C and the old C goes to bit 7. Only the C enable is high.
- R6: Code 10 rotates A left by one and code 11 rotates A right by one. Code 14 exchanges the two nibbles of A.
- R7: Codes 3, 4 and 5 give A AND S, A OR S and A XOR S. Code 6 gives 00h and code 7 gives the bitwise complement of A.
- R8: Code 8 gives A+1 with FFh wrapping to 00h. Code 9 gives A-1 with 00h wrapping to FFh.
- R9: For codes 3 to 11 and 14, all three flag enables are low and the result enable is high.
- R10: Codes 17 to 31 return A unchanged with the result enable and every flag enable low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 5 | Operation code |
| acc_i | input | 8 | Accumulator operand A |
| src_i | input | 8 | Second operand S |
| cy_i | input | 1 | Incoming carry flag |
| ac_i | input | 1 | Incoming half-carry flag |
| res_o | output | 8 | Result byte |
| res_we_o | output | 1 | Result should be written back |
| cy_o | output | 1 | New carry flag |
| ac_o | output | 1 | New half-carry flag |
| ov_o | output | 1 | New overflow flag |
| cy_we_o | output | 1 | Carry flag should be written |
| ac_we_o | output | 1 | Half-carry flag should be written |
| ov_we_o | output | 1 | Overflow flag should be written |
| ne_o | output | 1 | Compare found A different from S |

## Verification
The assertions are checked on every input change. They cover these properties:
- the 9-bit sum and difference identities for add and subtract;
- the unsigned compare and its suppressed write;
- the one-step increment and decrement;
- the rule that decimal adjust never clears carry;
- the silent enables for logic, plain rotate and unused codes.

The half-carry and signed-overflow values, the exact decimal-adjust corrections, the through-carry rotates and the nibble swap are confirmed only by the bench. It sweeps every A and S byte with both carry values for the arithmetic codes, and every A with all carry and half-carry combinations for the one-operand codes. It compares each result against its own arithmetic model.

// File: rtl/byte_alu_pkg.sv
package byte_alu_pkg;
    localparam int DATA_W = 8;
    localparam int NIB_W  = DATA_W / 2;
    localparam int OP_W   = 5;

    typedef enum logic [OP_W-1:0] {
        OP_ADD     = 5'd0,
        OP_ADD_CY  = 5'd1,
        OP_SUB_BRW = 5'd2,
        OP_AND     = 5'd3,
        OP_OR      = 5'd4,
        OP_XOR     = 5'd5,
        OP_CLR     = 5'd6,
        OP_CPL     = 5'd7,
        OP_INC     = 5'd8,
        OP_DEC     = 5'd9,
        OP_ROL     = 5'd10,
        OP_ROR     = 5'd11,
        OP_ROL_C   = 5'd12,
        OP_ROR_C   = 5'd13,
        OP_SWAP    = 5'd14,
        OP_CMP     = 5'd15,
        OP_DEC_ADJ = 5'd16
    } op_e;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub
    import byte_alu_pkg::*;
(
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              cin_i,
    input  logic              sub_i,
    output logic [DATA_W-1:0] sum_o,
    output logic              cy_o,
    output logic              hc_o,
    output logic              ov_o
);
    localparam int HB = NIB_W;
    localparam int TB = DATA_W - 1;

    logic [DATA_W-1:0] b_eff;
    logic              c_eff;
    logic [DATA_W:0]   s;
    logic              c_hb, c_tb, c_out;

    // Subtraction as a + ~b + ~borrow; every carry then inverts to a borrow.
    always_comb begin
        b_eff = sub_i ? ~b_i : b_i;
        c_eff = sub_i ? ~cin_i : cin_i;
        s     = {1'b0, a_i} + {1'b0, b_eff} + {{DATA_W{1'b0}}, c_eff};
        c_hb  = a_i[HB] ^ b_eff[HB] ^ s[HB];
        c_tb  = a_i[TB] ^ b_eff[TB] ^ s[TB];
        c_out = s[DATA_W];
        sum_o = s[DATA_W-1:0];
        cy_o  = c_out ^ sub_i;
        hc_o  = c_hb ^ sub_i;
        ov_o  = c_out ^ c_tb;
    end
endmodule

// File: rtl/alu_dec_adj.sv
module alu_dec_adj
    import byte_alu_pkg::*;
(
    input  logic [DATA_W-1:0] a_i,
    input  logic              cy_i,
    input  logic              hc_i,
    output logic [DATA_W-1:0] r_o,
    output logic              cy_o
);
    localparam logic [NIB_W-1:0] NINE = NIB_W'(9);
    localparam logic [DATA_W:0]  LO_FIX = (DATA_W+1)'(6);
    localparam logic [DATA_W:0]  HI_FIX = (DATA_W+1)'(6) << NIB_W;

    logic [DATA_W:0] t, u;
    logic            c_mid;

    always_comb begin
        t     = {1'b0, a_i} + (((a_i[NIB_W-1:0] > NINE) || hc_i) ? LO_FIX : '0);
        c_mid = cy_i | t[DATA_W];
        u     = {1'b0, t[DATA_W-1:0]} +
                ((c_mid || (t[DATA_W-1:NIB_W] > NINE)) ? HI_FIX : '0);
        r_o   = u[DATA_W-1:0];
        cy_o  = c_mid | u[DATA_W];
    end
endmodule

// File: rtl/alu_shift_logic.sv
module alu_shift_logic
    import byte_alu_pkg::*;
(
    input  op_e               op_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              cy_i,
    output logic [DATA_W-1:0] r_o,
    output logic              cy_o
);
    localparam int TB = DATA_W - 1;

    always_comb begin
        r_o  = a_i;
        cy_o = cy_i;
        unique case (op_i)
            OP_AND:   r_o = a_i & b_i;
            OP_OR:    r_o = a_i | b_i;
            OP_XOR:   r_o = a_i ^ b_i;
            OP_CLR:   r_o = '0;
            OP_CPL:   r_o = ~a_i;
            OP_INC:   r_o = a_i + DATA_W'(1);
            OP_DEC:   r_o = a_i - DATA_W'(1);
            OP_ROL:   r_o = {a_i[TB-1:0], a_i[TB]};
            OP_ROR:   r_o = {a_i[0], a_i[TB:1]};
            OP_ROL_C: begin r_o = {a_i[TB-1:0], cy_i}; cy_o = a_i[TB]; end
            OP_ROR_C: begin r_o = {cy_i, a_i[TB:1]};   cy_o = a_i[0];  end
            OP_SWAP:  r_o = {a_i[NIB_W-1:0], a_i[DATA_W-1:NIB_W]};
            default:  r_o = a_i;
        endcase
    end
endmodule

// File: rtl/byte_alu.sv
module byte_alu
    import byte_alu_pkg::*;
(
    input  logic [OP_W-1:0]   op_i,
    input  logic [DATA_W-1:0] acc_i,
    input  logic [DATA_W-1:0] src_i,
    input  logic              cy_i,
    input  logic              ac_i,
    output logic [DATA_W-1:0] res_o,
    output logic              res_we_o,
    output logic              cy_o,
    output logic              ac_o,
    output logic              ov_o,
    output logic              cy_we_o,
    output logic              ac_we_o,
    output logic              ov_we_o,
    output logic              ne_o
);
    op_e               op;
    logic              as_sub, as_cin;
    logic [DATA_W-1:0] as_sum, da_r, sl_r;
    logic              as_cy, as_hc, as_ov, da_cy, sl_cy;

    assign op     = op_e'(op_i);
    assign as_sub = (op == OP_SUB_BRW) || (op == OP_CMP);
    assign as_cin = ((op == OP_ADD_CY) || (op == OP_SUB_BRW)) ? cy_i : 1'b0;

    alu_addsub u_addsub (
        .a_i(acc_i), .b_i(src_i), .cin_i(as_cin), .sub_i(as_sub),
        .sum_o(as_sum), .cy_o(as_cy), .hc_o(as_hc), .ov_o(as_ov)
    );

    alu_dec_adj u_dec_adj (
        .a_i(acc_i), .cy_i(cy_i), .hc_i(ac_i), .r_o(da_r), .cy_o(da_cy)
    );

    alu_shift_logic u_shift_logic (
        .op_i(op), .a_i(acc_i), .b_i(src_i), .cy_i(cy_i),
        .r_o(sl_r), .cy_o(sl_cy)
    );

    always_comb begin
        res_o    = acc_i;
        res_we_o = 1'b0;
        cy_o     = cy_i;
        ac_o     = ac_i;
        ov_o     = 1'b0;
        cy_we_o  = 1'b0;
        ac_we_o  = 1'b0;
        ov_we_o  = 1'b0;
        ne_o     = 1'b0;
        unique case (op)
            OP_ADD, OP_ADD_CY, OP_SUB_BRW: begin
                res_o    = as_sum;
                res_we_o = 1'b1;
                cy_o     = as_cy;
                ac_o     = as_hc;
                ov_o     = as_ov;
                cy_we_o  = 1'b1;
                ac_we_o  = 1'b1;
                ov_we_o  = 1'b1;
            end
            OP_CMP: begin
                cy_o    = as_cy;
                cy_we_o = 1'b1;
                ne_o    = |as_sum;
            end
            OP_DEC_ADJ: begin
                res_o    = da_r;
                res_we_o = 1'b1;
                cy_o     = da_cy;
                cy_we_o  = 1'b1;
            end
            OP_ROL_C, OP_ROR_C: begin
                res_o    = sl_r;
                res_we_o = 1'b1;
                cy_o     = sl_cy;
                cy_we_o  = 1'b1;
            end
            OP_AND, OP_OR, OP_XOR, OP_CLR, OP_CPL, OP_INC, OP_DEC,
            OP_ROL, OP_ROR, OP_SWAP: begin
                res_o    = sl_r;
                res_we_o = 1'b1;
            end
            default: begin
                res_o = acc_i;
            end
        endcase
    end
endmodule

// File: rtl/byte_alu_chk.sv
module byte_alu_chk
    import byte_alu_pkg::*;
(
    input logic [OP_W-1:0]   op_i,
    input logic [DATA_W-1:0] acc_i,
    input logic [DATA_W-1:0] src_i,
    input logic              cy_i,
    input logic              ac_i,
    input logic [DATA_W-1:0] res_o,
    input logic              res_we_o,
    input logic              cy_o,
    input logic              ac_o,
    input logic              ov_o,
    input logic              cy_we_o,
    input logic              ac_we_o,
    input logic              ov_we_o,
    input logic              ne_o
);
    logic [DATA_W:0] wide_sum, wide_dif;
    logic            quiet;

    always_comb begin
        wide_sum = {1'b0, acc_i} + {1'b0, src_i} +
                   {{DATA_W{1'b0}}, (op_i == OP_ADD_CY) & cy_i};
        wide_dif = {1'b0, acc_i} - {1'b0, src_i} - {{DATA_W{1'b0}}, cy_i};
        quiet    = !cy_we_o && !ac_we_o && !ov_we_o;
        if (op_i == OP_ADD || op_i == OP_ADD_CY) begin
            assert_add_sum_R1: assert ({cy_o, res_o} == wide_sum && res_we_o)
                else $error("R1 add sum mismatch");
        end
        if (op_i == OP_SUB_BRW) begin
            assert_sub_diff_R2: assert ({cy_o, res_o} == wide_dif && ov_we_o)
                else $error("R2 subtract mismatch");
        end
        if (op_i == OP_CMP) begin
            assert_cmp_only_carry_R3: assert (!res_we_o && res_o == acc_i &&
                    cy_we_o && !ac_we_o && !ov_we_o &&
                    cy_o == (acc_i < src_i) && ne_o == (acc_i != src_i))
                else $error("R3 compare mismatch");
        end else begin
            assert_ne_idle_R3: assert (!ne_o) else $error("R3 ne outside compare");
        end
        if (op_i == OP_DEC_ADJ && cy_i) begin
            assert_da_keeps_carry_R4: assert (cy_o && cy_we_o && !ov_we_o)
                else $error("R4 carry cleared by adjust");
        end
        if (op_i == OP_INC) begin
            assert_inc_wrap_R8: assert (res_o == DATA_W'(acc_i + 1'b1))
                else $error("R8 increment mismatch");
        end
        if (op_i == OP_DEC) begin
            assert_dec_wrap_R8: assert (res_o == DATA_W'(acc_i - 1'b1))
                else $error("R8 decrement mismatch");
        end
        if (op_i >= OP_AND && op_i <= OP_ROR || op_i == OP_SWAP) begin
            assert_no_flag_write_R9: assert (quiet && res_we_o)
                else $error("R9 flag enable on flagless op");
        end
        if (op_i > OP_DEC_ADJ) begin
            assert_unused_idle_R10: assert (quiet && !res_we_o && res_o == acc_i)
                else $error("R10 unused code not idle");
        end
    end
endmodule

bind byte_alu byte_alu_chk u_chk (
    .op_i(op_i), .acc_i(acc_i), .src_i(src_i), .cy_i(cy_i), .ac_i(ac_i),
    .res_o(res_o), .res_we_o(res_we_o), .cy_o(cy_o), .ac_o(ac_o), .ov_o(ov_o),
    .cy_we_o(cy_we_o), .ac_we_o(ac_we_o), .ov_we_o(ov_we_o), .ne_o(ne_o)
);

// File: tb/byte_alu_tb.sv
`timescale 1ns/1ps
module byte_alu_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] op_i = 5'd31;
    logic [7:0] acc_i = 8'h00, src_i = 8'h00;
    logic       cy_i = 1'b0, ac_i = 1'b0;
    logic [7:0] res_o;
    logic       res_we_o, cy_o, ac_o, ov_o, cy_we_o, ac_we_o, ov_we_o, ne_o;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    byte_alu u_dut (
        .op_i(op_i), .acc_i(acc_i), .src_i(src_i), .cy_i(cy_i), .ac_i(ac_i),
        .res_o(res_o), .res_we_o(res_we_o), .cy_o(cy_o), .ac_o(ac_o),
        .ov_o(ov_o), .cy_we_o(cy_we_o), .ac_we_o(ac_we_o), .ov_we_o(ov_we_o),
        .ne_o(ne_o)
    );

    always @(posedge clk) begin
        if (rst_n) cycles <= cycles + 1;
        if (cycles > 180000 && !done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: run hung, actual cycles=%0d expected<=180000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    function automatic string req_of(input int op);
        case (op)
            0, 1:            return "R1";
            2:               return "R2";
            15:              return "R3";
            16:              return "R4";
            12, 13:          return "R5";
            10, 11, 14:      return "R6";
            3, 4, 5, 6, 7:   return "R7";
            8, 9:            return "R8";
            default:         return "R10";
        endcase
    endfunction

    // Drive one vector, model it from the requirements and compare.
    task automatic run_vec(input int op, input int a, input int b,
                           input int c, input int h);
        int r, sc, sv, t;
        bit ec, eh, ev, wr, wc, wh, wv, ne;
        string rq;
        op_i = 5'(op); acc_i = 8'(a); src_i = 8'(b); cy_i = c[0]; ac_i = h[0];
        #1;
        r = a; ec = c[0]; eh = h[0]; ev = 1'b0; ne = 1'b0;
        wr = 1'b1; wc = 1'b0; wh = 1'b0; wv = 1'b0;
        case (op)
            0, 1: begin
                sc = (op == 1) ? c : 0;
                t  = a + b + sc;
                sv = $signed(8'(a)) + $signed(8'(b)) + sc;
                r = t & 255; ec = t > 255; eh = ((a & 15) + (b & 15) + sc) > 15;
                ev = (sv > 127) || (sv < -128); wc = 1; wh = 1; wv = 1;
            end
            2: begin
                t  = a - b - c;
                sv = $signed(8'(a)) - $signed(8'(b)) - c;
                r = t & 255; ec = t < 0; eh = (a & 15) < ((b & 15) + c);
                ev = (sv > 127) || (sv < -128); wc = 1; wh = 1; wv = 1;
            end
            3: r = a & b;
            4: r = a | b;
            5: r = a ^ b;
            6: r = 0;
            7: r = (~a) & 255;
            8: r = (a + 1) & 255;
            9: r = (a + 255) & 255;
            10: r = ((a << 1) | (a >> 7)) & 255;
            11: r = ((a >> 1) | (a << 7)) & 255;
            12: begin r = ((a << 1) | c) & 255; ec = a[7]; wc = 1; end
            13: begin r = (a >> 1) | (c << 7); ec = a[0]; wc = 1; end
            14: r = ((a << 4) | (a >> 4)) & 255;
            15: begin r = a; wr = 0; ec = a < b; wc = 1; ne = (a != b); end
            16: begin
                t = a; ec = c[0];
                if ((t & 15) > 9 || h != 0) begin
                    t = t + 6; if (t > 255) ec = 1; t = t & 255;
                end
                if (ec || (t >> 4) > 9) begin
                    t = t + 8'h60; if (t > 255) ec = 1; t = t & 255;
                end
                r = t; wc = 1;
            end
            default: begin r = a; wr = 0; end
        endcase
        rq = req_of(op);
        if ((op >= 3 && op <= 11) || op == 14) rq = {rq, "/R9"};
        checks++;
        if (res_o != 8'(r) || res_we_o != wr || cy_we_o != wc || ac_we_o != wh ||
            ov_we_o != wv || ne_o != ne || (wc && cy_o != ec) ||
            (wh && ac_o != eh) || (wv && ov_o != ev)) begin
            errors++;
            $display("FAIL %s op=%0d a=%02h b=%02h c=%0d h=%0d actual res=%02h we=%b%b%b%b c/ac/ov=%b%b%b ne=%b expected res=%02h we=%b%b%b%b c/ac/ov=%b%b%b ne=%b",
                     rq, op, a, b, c, h, res_o, res_we_o, cy_we_o, ac_we_o, ov_we_o,
                     cy_o, ac_o, ov_o, ne_o, 8'(r), wr, wc, wh, wv, ec, eh, ev, ne);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // Idle state after reset: unused code 31 passes A through (R10).
        run_vec(31, 0, 0, 0, 0);
        // R1, R2, R3: every A, S and carry for add, add with carry, subtract, compare.
        for (int op = 0; op < 3; op++)
            for (int a = 0; a < 256; a++)
                for (int b = 0; b < 256; b++)
                    for (int c = 0; c < 2; c++) run_vec(op, a, b, c, 0);
        for (int a = 0; a < 256; a++)
            for (int b = 0; b < 256; b++)
                for (int c = 0; c < 2; c++) run_vec(15, a, b, c, 0);
        // R7, R9: bitwise logic with a strided second operand.
        for (int op = 3; op < 6; op++)
            for (int a = 0; a < 256; a++)
                for (int b = 0; b < 256; b += 7) run_vec(op, a, b, 0, 0);
        // R4, R5, R6, R7, R8: one-operand codes, all A and flag combinations.
        for (int op = 6; op < 17; op++)
            if (op != 15)
                for (int a = 0; a < 256; a++)
                    for (int fl = 0; fl < 4; fl++) run_vec(op, a, 8'h5A, fl & 1, fl >> 1);
        // R8 boundaries named explicitly.
        run_vec(8, 255, 0, 0, 0);
        run_vec(9, 0, 0, 0, 0);
        // R10: every unused code.
        for (int op = 17; op < 32; op++)
            for (int a = 0; a < 256; a += 3) run_vec(op, a, 255 - a, a & 1, 1);
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule